// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Process-ID Matching

This block is a software-managed translation buffer that maps 32-bit virtual addresses onto physical addresses in 4 KB pages. A lookup is purely combinational. The caller presents a virtual address, an access kind and the current process ID. In the same cycle the block returns a hit flag, the physical address, the read/write/execute rights of the matching entry and a permission-fault flag. All ways are compared in parallel, and the lowest-numbered way that matches supplies the result.

Entries sit in a register array of `NUM_ENTRIES` slots, split into `NUM_WAYS` ways. A management block fills the array through a one-entry write port. It can clear the valid flag of every private entry that belongs to one process ID through an invalidate port. It can read any slot back through a combinational read port.

The slot that a (way, VPN) pair selects is `way * NUM_WAYS + (VPN & SET_MASK)`, where `SET_MASK = NUM_ENTRIES/NUM_WAYS - 1`. The defaults are 64 entries, 8 ways and 8 PID bits, so every slot of every way lands inside the array.

Top module: `tlb_lookup`

## Requirements
- R1: The VPN is `vaddr[31:12]`. The slot of way w is `w*NUM_WAYS + (VPN & SET_MASK)`. On a hit, `lk_paddr` is the entry's 20-bit PFN in bits 31:12, with `vaddr[11:0]` passed through unchanged.
- R2: A way matches when its stored VPN equals the address VPN and either its global flag is 1 or its stored PID equals `lk_pid`. The valid flag takes no part in matching.
- R3: When more than one way matches, the lowest-numbered way supplies the result.
- R4: On a miss, `lk_hit`, `lk_paddr`, all three permission outputs and `lk_fault` are 0.
- R5: On a hit, `lk_perm_r`, `lk_perm_w` and `lk_perm_x` equal the R, W and X flags of the matching entry.
- R6: The access kind is encoded 0 = read, 1 = write, 2 = fetch and 3 = reserved. `lk_fault` is 1 exactly when there is a hit and the right for the access kind is clear. Code 3 faults on every hit.
- R7: A write takes effect at the clock edge and is visible from the next cycle, never in the cycle it is presented. It stores tag {VPN in 31:12, global in 11, valid = 1 in 10, PID in the low PID_BITS bits}. It stores data {R in 22, W in 21, X in 20, PFN in 19:0}. All other bits read 0.
- R8: Invalidate clears bit 10 of every entry whose valid flag is set, whose global flag is clear and whose PID equals `inv_pid`. It leaves every other entry unchanged. A write in the same cycle to the same slot wins. Lookup results do not change because of an invalidate.
- R9: Reset clears every tag and data word to 0. After reset, a lookup of VPN 0 with PID 0 therefore hits with no rights and faults on a read.
- R10: `rd_tag` and `rd_data` show, in the same cycle, the slot that `rd_way` and `rd_vpn` select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 fetch) |
| lk_pid | input | PID_BITS | Current process ID |
| lk_hit | output | 1 | A way matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm_r | output | 1 | Read right of the matching entry |
| lk_perm_w | output | 1 | Write right of the matching entry |
| lk_perm_x | output | 1 | Execute right of the matching entry |
| lk_fault | output | 1 | Hit without the right for the access kind |
| wr_en | input | 1 | Write one entry at the next edge |
| wr_way | input | log2(NUM_WAYS) | Way to write |
| wr_vpn | input | 20 | VPN to store, also selects the set |
| wr_pid | input | PID_BITS | PID to store |
| wr_global | input | 1 | Global flag to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_r | input | 1 | Read right to store |
| wr_w | input | 1 | Write right to store |
| wr_x | input | 1 | Execute right to store |
| inv_en | input | 1 | Invalidate private entries of one PID |
| inv_pid | input | PID_BITS | PID to invalidate |
| rd_way | input | log2(NUM_WAYS) | Way of the slot to read back |
| rd_vpn | input | 20 | VPN selecting the set to read back |
| rd_tag | output | 32 | Tag word of the selected slot |
| rd_data | output | 32 | Data word of the selected slot |

## Verification
The lookup outputs and the read-back port are combinational, so their results are due in the same cycle as the stimulus. The bench drives new values on the falling edge and samples one nanosecond later, before the next rising edge. Write and invalidate results are due one cycle later. The bench holds the request across exactly one rising edge and checks at the following falling edge. Before that edge, it also checks that a newly presented entry does not hit yet.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_BITS  = 12;
  localparam int VPN_W      = 20;
  localparam int PFN_W      = 20;
  localparam int PID_MAX_W  = 10;
  localparam int TAG_G_BIT  = 11;
  localparam int TAG_V_BIT  = 10;
  localparam int DAT_R_BIT  = 22;
  localparam int DAT_W_BIT  = 21;
  localparam int DAT_X_BIT  = 20;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [VPN_W-1:0]     vpn;
    logic                 glob;
    logic                 vld;
    logic [PID_MAX_W-1:0] pid;
    logic                 pr;
    logic                 pw;
    logic                 px;
    logic [PFN_W-1:0]     pfn;
  } tlb_ent_t;

  typedef struct packed {
    logic             pr;
    logic             pw;
    logic             px;
    logic [PFN_W-1:0] pfn;
  } tlb_xlat_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_WAYS    = 8,
  parameter int PID_BITS    = 8,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SET_MASK   = NUM_ENTRIES / NUM_WAYS - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PID_BITS-1:0]           wr_pid,
  input  logic                          wr_global,
  input  logic [PFN_W-1:0]              wr_pfn,
  input  logic                          wr_r,
  input  logic                          wr_w,
  input  logic                          wr_x,
  input  logic                          inv_en,
  input  logic [PID_BITS-1:0]           inv_pid,
  output tlb_ent_t [NUM_ENTRIES-1:0]    ents_o
);
  tlb_ent_t [NUM_ENTRIES-1:0] ents_q, ents_d;
  tlb_ent_t                   wr_ent;
  logic [31:0]                wr_slot;
  logic                       upd_en;

  always_comb begin
    wr_ent      = '0;
    wr_ent.vpn  = wr_vpn;
    wr_ent.glob = wr_global;
    wr_ent.vld  = 1'b1;
    wr_ent.pid  = PID_MAX_W'(wr_pid);
    wr_ent.pr   = wr_r;
    wr_ent.pw   = wr_w;
    wr_ent.px   = wr_x;
    wr_ent.pfn  = wr_pfn;
    wr_slot     = (32'(wr_way) << WAY_W) + (32'(wr_vpn) & 32'(SET_MASK));
  end

  // next state: invalidate first, then the write overrides its own slot
  always_comb begin
    ents_d = ents_q;
    if (inv_en) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (ents_q[e].vld && !ents_q[e].glob &&
            ents_q[e].pid == PID_MAX_W'(inv_pid))
          ents_d[e].vld = 1'b0;
      end
    end
    if (wr_en && wr_slot < 32'(NUM_ENTRIES))
      ents_d[wr_slot[IDX_W-1:0]] = wr_ent;
  end

  assign upd_en = wr_en | inv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ents_q <= '0;
    else if (upd_en) ents_q <= ents_d;
  end

  assign ents_o = ents_q;
endmodule

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp import tlb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_WAYS    = 8,
  parameter int PID_BITS    = 8,
  parameter int WAY         = 0,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SET_MASK   = NUM_ENTRIES / NUM_WAYS - 1
) (
  input  tlb_ent_t [NUM_ENTRIES-1:0] ents_i,
  input  logic [VPN_W-1:0]           vpn_i,
  input  logic [PID_BITS-1:0]        pid_i,
  output logic                       match_o,
  output tlb_xlat_t                  xlat_o
);
  logic [31:0] slot;
  tlb_ent_t    ent;

  always_comb begin
    slot    = 32'(WAY * NUM_WAYS) + (32'(vpn_i) & 32'(SET_MASK));
    ent     = '0;
    match_o = 1'b0;
    if (slot < 32'(NUM_ENTRIES)) begin
      ent     = ents_i[slot[IDX_W-1:0]];
      match_o = (ent.vpn == vpn_i) &&
                (ent.glob || ent.pid == PID_MAX_W'(pid_i));
    end
    xlat_o = '{pr: ent.pr, pw: ent.pw, px: ent.px, pfn: ent.pfn};
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick import tlb_pkg::*; #(
  parameter int NUM_WAYS = 8
) (
  input  logic [NUM_WAYS-1:0]      match_i,
  input  tlb_xlat_t [NUM_WAYS-1:0] xlat_i,
  input  logic [1:0]               acc_i,
  input  logic [PAGE_BITS-1:0]     offset_i,
  output logic                     hit_o,
  output logic [31:0]              paddr_o,
  output logic                     pr_o,
  output logic                     pw_o,
  output logic                     px_o,
  output logic                     fault_o
);
  tlb_xlat_t sel;
  logic      allowed;

  // lowest-numbered matching way wins
  always_comb begin
    hit_o = 1'b0;
    sel   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (match_i[w] && !hit_o) begin
        hit_o = 1'b1;
        sel   = xlat_i[w];
      end
    end
  end

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_LOAD:  allowed = sel.pr;
      ACC_STORE: allowed = sel.pw;
      ACC_FETCH: allowed = sel.px;
      default:   allowed = 1'b0;
    endcase
  end

  assign paddr_o = hit_o ? {sel.pfn, offset_i} : 32'h0;
  assign pr_o    = sel.pr;
  assign pw_o    = sel.pw;
  assign px_o    = sel.px;
  assign fault_o = hit_o & ~allowed;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup import tlb_pkg::*; #(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_WAYS    = 8,
  parameter int PID_BITS    = 8,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SET_MASK   = NUM_ENTRIES / NUM_WAYS - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         lk_vaddr,
  input  logic [1:0]          lk_acc,
  input  logic [PID_BITS-1:0] lk_pid,
  output logic                lk_hit,
  output logic [31:0]         lk_paddr,
  output logic                lk_perm_r,
  output logic                lk_perm_w,
  output logic                lk_perm_x,
  output logic                lk_fault,
  input  logic                wr_en,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic [19:0]         wr_vpn,
  input  logic [PID_BITS-1:0] wr_pid,
  input  logic                wr_global,
  input  logic [19:0]         wr_pfn,
  input  logic                wr_r,
  input  logic                wr_w,
  input  logic                wr_x,
  input  logic                inv_en,
  input  logic [PID_BITS-1:0] inv_pid,
  input  logic [WAY_W-1:0]    rd_way,
  input  logic [19:0]         rd_vpn,
  output logic [31:0]         rd_tag,
  output logic [31:0]         rd_data
);
  tlb_ent_t [NUM_ENTRIES-1:0] ents;
  logic [NUM_WAYS-1:0]        way_match;
  tlb_xlat_t [NUM_WAYS-1:0]   way_xlat;
  logic [VPN_W-1:0]           lk_vpn;
  logic [31:0]                rd_slot;
  tlb_ent_t                   rd_ent;

  assign lk_vpn = lk_vaddr[31:PAGE_BITS];

  tlb_store #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_WAYS(NUM_WAYS), .PID_BITS(PID_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_way(wr_way), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
    .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_r(wr_r), .wr_w(wr_w), .wr_x(wr_x),
    .inv_en(inv_en), .inv_pid(inv_pid), .ents_o(ents)
  );

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    tlb_way_cmp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_WAYS(NUM_WAYS),
                  .PID_BITS(PID_BITS), .WAY(g)) u_cmp (
      .ents_i(ents), .vpn_i(lk_vpn), .pid_i(lk_pid),
      .match_o(way_match[g]), .xlat_o(way_xlat[g])
    );
  end

  tlb_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .match_i(way_match), .xlat_i(way_xlat), .acc_i(lk_acc),
    .offset_i(lk_vaddr[PAGE_BITS-1:0]),
    .hit_o(lk_hit), .paddr_o(lk_paddr),
    .pr_o(lk_perm_r), .pw_o(lk_perm_w), .px_o(lk_perm_x), .fault_o(lk_fault)
  );

  // management read-back port
  always_comb begin
    rd_slot = (32'(rd_way) << WAY_W) + (32'(rd_vpn) & 32'(SET_MASK));
    rd_ent  = '0;
    if (rd_slot < 32'(NUM_ENTRIES)) rd_ent = ents[rd_slot[IDX_W-1:0]];
    rd_tag  = '0;
    rd_tag[31:PAGE_BITS]  = rd_ent.vpn;
    rd_tag[TAG_G_BIT]     = rd_ent.glob;
    rd_tag[TAG_V_BIT]     = rd_ent.vld;
    rd_tag[PID_BITS-1:0]  = rd_ent.pid[PID_BITS-1:0];
    rd_data = '0;
    rd_data[DAT_R_BIT]    = rd_ent.pr;
    rd_data[DAT_W_BIT]    = rd_ent.pw;
    rd_data[DAT_X_BIT]    = rd_ent.px;
    rd_data[PFN_W-1:0]    = rd_ent.pfn;
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_WAYS    = 8,
  parameter int PID_BITS    = 8,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int SET_MASK   = NUM_ENTRIES / NUM_WAYS - 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [31:0]         lk_vaddr,
  input logic [1:0]          lk_acc,
  input logic                lk_hit,
  input logic [31:0]         lk_paddr,
  input logic                lk_perm_r,
  input logic                lk_perm_w,
  input logic                lk_perm_x,
  input logic                lk_fault,
  input logic                wr_en,
  input logic [WAY_W-1:0]    wr_way,
  input logic [19:0]         wr_vpn,
  input logic                inv_en,
  input logic [PID_BITS-1:0] inv_pid,
  input logic [WAY_W-1:0]    rd_way,
  input logic [19:0]         rd_vpn,
  input logic [31:0]         rd_tag
);
  logic wr_ok;
  assign wr_ok = ((32'(wr_way) << WAY_W) + (32'(wr_vpn) & 32'(SET_MASK))) < 32'(NUM_ENTRIES);

  p_offset_thru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);

  p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == 32'h0 && !lk_fault && !lk_perm_r && !lk_perm_w && !lk_perm_x));

  p_read_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == 2'd0) |-> lk_fault == !lk_perm_r);

  p_fetch_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == 2'd2) |-> lk_fault == !lk_perm_x);

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_way != $past(wr_way) || rd_vpn != $past(wr_vpn) || !$past(wr_ok) ||
               (rd_tag[31:12] == $past(wr_vpn) && rd_tag[10])));

  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !wr_en) |=> (rd_tag[11] || !rd_tag[10] ||
                            rd_tag[PID_BITS-1:0] != $past(inv_pid)));
endmodule

bind tlb_lookup tlb_lookup_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_WAYS(NUM_WAYS), .PID_BITS(PID_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_hit(lk_hit),
  .lk_paddr(lk_paddr), .lk_perm_r(lk_perm_r), .lk_perm_w(lk_perm_w),
  .lk_perm_x(lk_perm_x), .lk_fault(lk_fault), .wr_en(wr_en), .wr_way(wr_way),
  .wr_vpn(wr_vpn), .inv_en(inv_en), .inv_pid(inv_pid), .rd_way(rd_way),
  .rd_vpn(rd_vpn), .rd_tag(rd_tag)
);

// File: tb/tlb_lookup_tb.sv
`timescale 1ns/1ps
module tlb_lookup_tb;
  localparam int NE = 64;
  localparam int NW = 8;
  localparam int PB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_acc;
  logic [7:0]  lk_pid;
  logic        lk_hit, lk_perm_r, lk_perm_w, lk_perm_x, lk_fault;
  logic [31:0] lk_paddr;
  logic        wr_en, wr_global, wr_r, wr_w, wr_x, inv_en;
  logic [2:0]  wr_way, rd_way;
  logic [19:0] wr_vpn, wr_pfn, rd_vpn;
  logic [7:0]  wr_pid, inv_pid;
  logic [31:0] rd_tag, rd_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tlb_lookup #(.NUM_ENTRIES(NE), .NUM_WAYS(NW), .PID_BITS(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm_r(lk_perm_r), .lk_perm_w(lk_perm_w),
    .lk_perm_x(lk_perm_x), .lk_fault(lk_fault), .wr_en(wr_en), .wr_way(wr_way),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_global(wr_global), .wr_pfn(wr_pfn),
    .wr_r(wr_r), .wr_w(wr_w), .wr_x(wr_x), .inv_en(inv_en), .inv_pid(inv_pid),
    .rd_way(rd_way), .rd_vpn(rd_vpn), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [7:0]  pid;
    logic        hit;
    logic [31:0] pa;
    logic [2:0]  rwx;
    logic        flt;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{32'h12345ABC, 2'd0, 8'h21, 1'b1, 32'hABCDEABC, 3'b100, 1'b0}, // R1 R3
    '{32'h12345ABC, 2'd1, 8'h21, 1'b1, 32'hABCDEABC, 3'b100, 1'b1}, // R6 write
    '{32'h12345ABC, 2'd0, 8'h55, 1'b1, 32'h11111ABC, 3'b111, 1'b0}, // R2 global
    '{32'h00400123, 2'd2, 8'h07, 1'b1, 32'h00080123, 3'b011, 1'b0}, // R5
    '{32'h00400123, 2'd0, 8'h07, 1'b1, 32'h00080123, 3'b011, 1'b1}, // R6 read
    '{32'h00400FFF, 2'd1, 8'h09, 1'b1, 32'h00090FFF, 3'b110, 1'b0}, // R2 pid
    '{32'h00400000, 2'd0, 8'h08, 1'b0, 32'h00000000, 3'b000, 1'b0}, // R4
    '{32'h12346ABC, 2'd0, 8'h21, 1'b0, 32'h00000000, 3'b000, 1'b0}, // R4 vpn
    '{32'h00400010, 2'd3, 8'h09, 1'b1, 32'h00090010, 3'b110, 1'b1}, // R6 rsvd
    '{32'h00000010, 2'd0, 8'h00, 1'b1, 32'h00000010, 3'b000, 1'b1}, // R9
    '{32'h00000010, 2'd0, 8'h01, 1'b0, 32'h00000000, 3'b000, 1'b0}  // R2 R9
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] pid);
    @(negedge clk);
    lk_vaddr = va; lk_acc = acc; lk_pid = pid;
    #1;
  endtask

  task automatic look_chk(input string req, input vec_t v);
    look(v.va, v.acc, v.pid);
    chk({req, " hit"},   64'(lk_hit), 64'(v.hit));
    chk({req, " paddr"}, 64'(lk_paddr), 64'(v.pa));
    chk({req, " rwx"},   64'({lk_perm_r, lk_perm_w, lk_perm_x}), 64'(v.rwx));
    chk({req, " fault"}, 64'(lk_fault), 64'(v.flt));
  endtask

  task automatic rdback(input logic [2:0] way, input logic [19:0] vpn);
    @(negedge clk);
    rd_way = way; rd_vpn = vpn;
    #1;
  endtask

  task automatic put(input logic [2:0] way, input logic [19:0] vpn, input logic [7:0] pid,
                     input logic g, input logic [19:0] pfn, input logic [2:0] rwx);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_vpn = vpn; wr_pid = pid; wr_global = g;
    wr_pfn = pfn; {wr_r, wr_w, wr_x} = rwx;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_vaddr = '0; lk_acc = '0; lk_pid = '0;
    wr_en = 1'b0; wr_way = '0; wr_vpn = '0; wr_pid = '0; wr_global = 1'b0;
    wr_pfn = '0; wr_r = 1'b0; wr_w = 1'b0; wr_x = 1'b0;
    inv_en = 1'b0; inv_pid = '0; rd_way = '0; rd_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    rdback(3'd5, 20'h00003);
    chk("R9 reset tag", 64'(rd_tag), 64'h0);
    chk("R9 reset data", 64'(rd_data), 64'h0);
    look_chk("R9", VEC[9]);

    // R7: write not visible before the edge, visible after
    @(negedge clk);
    wr_en = 1'b1; wr_way = 3'd4; wr_vpn = 20'h07777; wr_pid = 8'h01; wr_global = 1'b0;
    wr_pfn = 20'h0CAFE; {wr_r, wr_w, wr_x} = 3'b100;
    lk_vaddr = 32'h07777004; lk_acc = 2'd0; lk_pid = 8'h01;
    #1;
    chk("R7 not yet", 64'(lk_hit), 64'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7 after edge hit", 64'(lk_hit), 64'h1);
    chk("R7 after edge paddr", 64'(lk_paddr), 64'h0CAFE004);

    // load the table entries
    put(3'd0, 20'h12345, 8'h21, 1'b0, 20'hABCDE, 3'b100);
    put(3'd1, 20'h12345, 8'h00, 1'b1, 20'h11111, 3'b111);
    put(3'd2, 20'h00400, 8'h07, 1'b0, 20'h00080, 3'b011);
    put(3'd3, 20'h00400, 8'h09, 1'b0, 20'h00090, 3'b110);

    // R7 R10: read-back layout
    rdback(3'd0, 20'h12345);
    chk("R10 R7 tag", 64'(rd_tag), 64'h12345421);
    chk("R10 R7 data", 64'(rd_data), 64'h004ABCDE);
    rdback(3'd1, 20'h12345);
    chk("R7 global tag", 64'(rd_tag), 64'h12345C00);

    // vector table
    for (int i = 0; i < 11; i++) look_chk($sformatf("R1-6 vec%0d", i), VEC[i]);

    // R8: invalidate PID 0x21
    @(negedge clk);
    inv_en = 1'b1; inv_pid = 8'h21;
    @(negedge clk);
    inv_en = 1'b0;
    rdback(3'd0, 20'h12345);
    chk("R8 cleared", 64'(rd_tag), 64'h12345021);
    rdback(3'd1, 20'h12345);
    chk("R8 global kept", 64'(rd_tag), 64'h12345C00);
    rdback(3'd2, 20'h00400);
    chk("R8 other pid kept", 64'(rd_tag), 64'h00400407);
    look_chk("R8 R2 lookup unchanged", VEC[0]);

    // R8: write beats invalidate on the same slot
    @(negedge clk);
    inv_en = 1'b1; inv_pid = 8'h09;
    wr_en = 1'b1; wr_way = 3'd3; wr_vpn = 20'h00400; wr_pid = 8'h09; wr_global = 1'b0;
    wr_pfn = 20'h00099; {wr_r, wr_w, wr_x} = 3'b001;
    @(negedge clk);
    inv_en = 1'b0; wr_en = 1'b0;
    rdback(3'd3, 20'h00400);
    chk("R8 write wins tag", 64'(rd_tag), 64'h00400409);
    chk("R8 write wins data", 64'(rd_data), 64'h00100099);
    look(32'h00400123, 2'd2, 8'h09);
    chk("R8 new paddr", 64'(lk_paddr), 64'h00099123);
    chk("R6 fetch ok", 64'(lk_fault), 64'h0);

    // R3: lower way shadows a later, higher duplicate
    put(3'd6, 20'h00400, 8'h07, 1'b0, 20'h00F00, 3'b111);
    look(32'h00400123, 2'd0, 8'h07);
    chk("R3 lowest way paddr", 64'(lk_paddr), 64'h00080123);
    chk("R3 lowest way fault", 64'(lk_fault), 64'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule